// File: doc/BRIEF.md
# LIN and UART Checksum Accumulator

This block maintains a running 8-bit checksum over the characters that pass between a serial transmitter and receiver. The checksum runs in one of four modes. Two inputs select the mode: a LIN-mode input and a one-bit checksum select. In LIN mode the select bit chooses between an enhanced sum, which counts the protected identifier character, and a classic sum, which leaves that character out. Outside LIN mode the select bit either enables a plain sum of every character or turns the checksum off.

Each accepted character raises a strobe for one cycle and comes with its value and two flags. One flag marks the protected identifier and the other marks the sync byte. The block presents the running sum, the byte to send as the checksum field, and a combinational match flag that compares the sum with a received checksum byte. A clear pulse starts a new frame. Framing, break handling and the serial engine are outside this block.

Top module: `lin_chk_acc`

## Requirements
- R1: After the asynchronous reset is released, sum_o reads 0x00.
- R2: When lin_mode_i=1 and sum_sel_i=1, each strobed character is added to the sum, including one flagged as PID. The addition is 8-bit with end-around carry: a carry out of bit 7 is added back into bit 0. The new sum appears on sum_o in the cycle after the strobe.
- R3: When lin_mode_i=1 and sum_sel_i=0, a strobed character with char_pid_i=1 leaves the sum unchanged. Other characters are added with end-around carry.
- R4: When lin_mode_i=0 and sum_sel_i=1, every strobed character is added modulo 256 with no carry fed back, whatever the PID flag.
- R5: When lin_mode_i=0 and sum_sel_i=0, the sum is forced to 0x00 on the next edge. Strobed characters are ignored and match_o is low.
- R6: With lin_mode_i=1, chk_tx_o is the bitwise inverse of sum_o. With lin_mode_i=0, chk_tx_o equals sum_o.
- R7: With lin_mode_i=1, match_o is high exactly when sum_o plus rx_chk_i, added with end-around carry, equals 0xFF. In the enabled non-LIN mode, match_o is high exactly when rx_chk_i equals sum_o.
- R8: When clear_i=1, the sum is 0x00 in the next cycle, even if a character is strobed in the same cycle.
- R9: A strobed character with char_sync_i=1 is never added, in any mode.
- R10: In a cycle with neither strobe nor clear, and the block enabled, the sum holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lin_mode_i | input | 1 | 1 selects the LIN checksum rules |
| sum_sel_i | input | 1 | LIN: 1 enhanced, 0 classic. Otherwise: 1 plain sum, 0 off |
| char_valid_i | input | 1 | One-cycle strobe for a character |
| char_data_i | input | 8 | Character value |
| char_pid_i | input | 1 | Character is the protected identifier |
| char_sync_i | input | 1 | Character is the sync byte |
| clear_i | input | 1 | Restart the sum at zero |
| rx_chk_i | input | 8 | Received checksum byte to compare |
| sum_o | output | 8 | Running sum |
| chk_tx_o | output | 8 | Checksum byte to transmit |
| match_o | output | 1 | Received checksum agrees with the sum |

## Verification
The assertions assume that the mode inputs do not change during a frame. Apart from the deliberate switch to the off mode, the stimulus changes mode only directly after a clear. The assertions also assume that each strobe lasts a single cycle, and that the PID and sync flags mean something only while the strobe is high. The bench drives every input on the falling edge and keeps rx_chk_i steady through the following rising edge, so the combinational match is compared against a settled sum. The stimulus also drives a clear together with a strobe, sync-flagged characters in each mode, and sums that wrap past 0xFF in both the end-around and modulo forms.

// File: rtl/lin_chk_pkg.sv
package lin_chk_pkg;

  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_PLAIN   = 2'b01,
    MODE_CLASSIC = 2'b10,
    MODE_ENH     = 2'b11
  } chk_mode_e;

  function automatic logic [DW-1:0] add_eac(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[DW-1:0] + {{(DW-1){1'b0}}, t[DW]};
  endfunction

endpackage

// File: rtl/lin_chk_dec.sv
module lin_chk_dec
  import lin_chk_pkg::*;
(
  input  logic      lin_mode_i,
  input  logic      sum_sel_i,
  input  logic      char_valid_i,
  input  logic      char_pid_i,
  input  logic      char_sync_i,
  output chk_mode_e mode_o,
  output logic      add_o
);

  always_comb begin
    unique case ({lin_mode_i, sum_sel_i})
      2'b11:   mode_o = MODE_ENH;
      2'b10:   mode_o = MODE_CLASSIC;
      2'b01:   mode_o = MODE_PLAIN;
      default: mode_o = MODE_OFF;
    endcase
  end

  always_comb begin
    add_o = char_valid_i && !char_sync_i;
    if (mode_o == MODE_OFF) add_o = 1'b0;
    if (mode_o == MODE_CLASSIC && char_pid_i) add_o = 1'b0;
  end

endmodule

// File: rtl/lin_chk_accum.sv
module lin_chk_accum
  import lin_chk_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  chk_mode_e    mode_i,
  input  logic         add_i,
  input  logic         clear_i,
  input  logic         char_valid_i,
  input  logic         char_sync_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] sum_q, sum_d;
  logic         eac;

  assign eac = (mode_i == MODE_ENH) || (mode_i == MODE_CLASSIC);

  always_comb begin
    sum_d = sum_q;
    if (clear_i || mode_i == MODE_OFF) sum_d = '0;
    else if (add_i) sum_d = eac ? add_eac(sum_q, data_i) : sum_q + data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  // R8
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> sum_q == '0);
  // R5
  off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> sum_q == '0);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!char_valid_i && !clear_i && mode_i != MODE_OFF) |=> $stable(sum_q));
  // R9
  sync_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && char_sync_i && !clear_i && mode_i != MODE_OFF) |=> $stable(sum_q));

endmodule

// File: rtl/lin_chk_cmp.sv
module lin_chk_cmp
  import lin_chk_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  chk_mode_e    mode_i,
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] rx_chk_i,
  output logic [W-1:0] chk_tx_o,
  output logic         match_o
);

  logic lin;
  assign lin = (mode_i == MODE_ENH) || (mode_i == MODE_CLASSIC);

  assign chk_tx_o = lin ? ~sum_i : sum_i;

  always_comb begin
    unique case (mode_i)
      MODE_OFF:   match_o = 1'b0;
      MODE_PLAIN: match_o = (rx_chk_i == sum_i);
      default:    match_o = (add_eac(sum_i, rx_chk_i) == {W{1'b1}});
    endcase
  end

  // R7
  tx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lin && rx_chk_i == chk_tx_o) |-> match_o);
  // R5
  off_nomatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |-> !match_o);

endmodule

// File: rtl/lin_chk_acc.sv
module lin_chk_acc
  import lin_chk_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lin_mode_i,
  input  logic          sum_sel_i,
  input  logic          char_valid_i,
  input  logic [DW-1:0] char_data_i,
  input  logic          char_pid_i,
  input  logic          char_sync_i,
  input  logic          clear_i,
  input  logic [DW-1:0] rx_chk_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] chk_tx_o,
  output logic          match_o
);

  chk_mode_e mode;
  logic      add;

  lin_chk_dec u_dec (
    .lin_mode_i  (lin_mode_i),
    .sum_sel_i   (sum_sel_i),
    .char_valid_i(char_valid_i),
    .char_pid_i  (char_pid_i),
    .char_sync_i (char_sync_i),
    .mode_o      (mode),
    .add_o       (add)
  );

  lin_chk_accum #(.W(DW)) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .add_i       (add),
    .clear_i     (clear_i),
    .char_valid_i(char_valid_i),
    .char_sync_i (char_sync_i),
    .data_i      (char_data_i),
    .sum_o       (sum_o)
  );

  lin_chk_cmp #(.W(DW)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .sum_i   (sum_o),
    .rx_chk_i(rx_chk_i),
    .chk_tx_o(chk_tx_o),
    .match_o (match_o)
  );

  // R3
  classic_pid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lin_mode_i && !sum_sel_i && char_valid_i && char_pid_i && !clear_i) |=> $stable(sum_o));
  // R6
  lin_tx_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_mode_i |-> ((chk_tx_o ^ sum_o) == {DW{1'b1}}));

endmodule

// File: tb/lin_chk_acc_tb.sv
module lin_chk_acc_tb;

  typedef struct {
    logic [7:0] sum;
    logic [7:0] tx;
    logic       match;
    string      tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic lin = 0, sel = 0, valid = 0, pid = 0, sync = 0, clr = 0;
  logic [7:0] data = 0, rx = 0;
  logic [7:0] sum, tx;
  logic match;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic [7:0] m_sum = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lin_chk_acc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lin_mode_i(lin), .sum_sel_i(sel),
    .char_valid_i(valid), .char_data_i(data), .char_pid_i(pid),
    .char_sync_i(sync), .clear_i(clr), .rx_chk_i(rx),
    .sum_o(sum), .chk_tx_o(tx), .match_o(match)
  );

  function automatic logic [7:0] m_eac(input logic [7:0] a, input logic [7:0] b);
    int t;
    t = int'(a) + int'(b);
    if (t > 255) t = t - 255;
    return t[7:0];
  endfunction

  task automatic step(input logic l, input logic s, input logic v, input logic [7:0] d,
                      input logic p, input logic sy, input logic c, input logic [7:0] r,
                      input string tag);
    exp_t e;
    logic off;
    @(negedge clk);
    lin = l; sel = s; valid = v; data = d; pid = p; sync = sy; clr = c; rx = r;
    off = !l && !s;
    if (c || off) m_sum = 8'h00;
    else if (v && !sy && !(l && !s && p)) m_sum = l ? m_eac(m_sum, d) : m_sum + d;
    e.sum   = m_sum;
    e.tx    = l ? ~m_sum : m_sum;
    e.match = off ? 1'b0 : (l ? (m_eac(m_sum, r) == 8'hFF) : (r == m_sum));
    e.tag   = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sum !== e.sum || tx !== e.tx || match !== e.match) begin
        errors++;
        $display("FAIL %s sum=%h tx=%h match=%b expected sum=%h tx=%h match=%b",
                 e.tag, sum, tx, match, e.sum, e.tx, e.match);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #25;
    checks++;
    if (sum !== 8'h00) begin
      errors++;
      $display("FAIL R1 sum=%h expected 00", sum);
    end
    rst_n = 1;

    // R2 enhanced: sync skipped, PID counted, wrap with end-around carry
    step(1,1,0,8'h00,0,0,1,8'h00,"R8");
    step(1,1,1,8'h55,0,1,0,8'h00,"R9");
    step(1,1,1,8'hC1,1,0,0,8'h00,"R2");
    step(1,1,1,8'hF0,0,0,0,8'h00,"R2");
    step(1,1,0,8'h00,0,0,0,8'h4D,"R7");
    step(1,1,0,8'h00,0,0,0,8'h4E,"R10");
    step(1,1,1,8'hFF,0,0,0,8'hB2,"R6");
    // R3 classic: PID skipped
    step(1,0,0,8'h00,0,0,1,8'h00,"R8");
    step(1,0,1,8'hA5,1,0,0,8'h00,"R3");
    step(1,0,1,8'h80,0,0,0,8'h00,"R3");
    step(1,0,1,8'h90,0,0,0,8'hEF,"R7");
    // R8 clear beats a strobe
    step(1,0,1,8'h33,0,0,1,8'h00,"R8");
    // R4 plain modulo sum, PID and wrap
    step(0,1,1,8'hF0,1,0,0,8'h00,"R4");
    step(0,1,1,8'h20,0,0,0,8'h10,"R4");
    step(0,1,1,8'h55,0,1,0,8'h10,"R9");
    step(0,1,0,8'h00,0,0,0,8'h11,"R7");
    step(0,1,0,8'h00,0,0,0,8'h10,"R6");
    // R5 off: forced zero, strobes ignored, no match
    step(0,0,1,8'h12,0,0,0,8'h00,"R5");
    step(0,0,1,8'h34,0,0,0,8'h00,"R5");
    step(0,0,0,8'h00,0,0,0,8'hFF,"R5");
    // R2 long enhanced frame
    step(1,1,0,8'h00,0,0,1,8'h00,"R8");
    for (int i = 0; i < 20; i++)
      step(1,1,1,8'(i * 37 + 11),(i == 0),0,0,8'(i),"R2");
    step(1,1,0,8'h00,0,0,0,~m_sum,"R7");
    step(1,1,0,8'h00,0,0,0,8'h00,"R10");
    @(negedge clk);
    valid = 0; clr = 0;
    repeat (3) @(posedge clk);
    #5;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule